// File: doc/BRIEF.md
# Bootstrap Copy Engine

The engine loads a short boot program into an embedded processor. The program sits in an always-on retained SRAM, and the engine copies it one 32-bit word at a time into the processor's instruction SRAM. A host fills the retained SRAM through a write window in the engine's register space. It then programs a source offset, a destination address and a word count. A copy can start in either of two ways. The host can start it directly, or it can arm the engine so that every later power-up event replays the same copy on its own. While a copy is in progress the engine holds the processor. It lets the processor run once the last word has been committed to instruction SRAM.

The retained SRAM has a registered read port with one cycle of latency. Reads run ahead through a two-entry queue, so the copy sustains one word per clock.

The instruction SRAM side is a valid/ready stream that carries an address and a data word:
- A word transfers on a rising edge where `imem_valid` and `imem_ready` are both high.
- While `imem_valid` is high and `imem_ready` is low, the address and data stay constant and `imem_valid` stays high.
- `imem_ready` may change in any cycle.
- Control pins (`pwr_up`, `cpu_hold`) and the register bus are plain, single-cycle signals.

Top module: `boot_copy_engine`

## Requirements
- R1: Register map, by byte offset: 0x000 control, 0x004 source byte offset, 0x008 destination byte address, 0x00C word count, 0x010 status. Source, destination and count read back the full 32-bit value last written. Control reads {bit31 = busy, bit30 = arm, zeros}. Status reads {zeros, bit0 = done}. All of these read 0 after reset. Read data is combinational while `reg_rd` is high and 0 otherwise.
- R2: Writing control with bit31 = 1 while idle starts a copy. Bit31 then reads 1 until the copy ends and 0 afterwards. Status bit0 clears at the start of a non-empty copy and reads 1 once it ends.
- R3: A copy of N words produces exactly N instruction writes, in order. Word i has data = retained word ((source[9:2] + i) mod 256) and address = destination[15:0] + 4·i.
- R4: With `imem_ready` held high, a copy of N ≥ 1 words holds `cpu_hold` high for exactly N+2 clock cycles after the start edge. Writes therefore arrive one per clock after the read-latency fill.
- R5: Back-pressure: while `imem_valid` is high and `imem_ready` is low, `imem_valid` stays high and the address and data stay stable. No word is lost or repeated.
- R6: A start with a word count of 0 makes no instruction write and never shows busy. It sets status bit0 and clears `cpu_hold` on the start edge.
- R7: Control bit30 is the arm bit. Writing it alone does not start a copy. A one-cycle `pwr_up` pulse starts a copy only while the arm bit is 1. Without it, `pwr_up` has no effect.
- R8: `cpu_hold` is 1 out of reset. It rises on the start edge of any non-empty copy and falls on the edge that commits the final write. A copy started by `pwr_up` therefore releases the processor with no host action.
- R9: A control start or a `pwr_up` that arrives while a copy is running is ignored. The running copy completes with exactly its N writes.
- R10: A host write to 0x400–0x7FC stores its data in retained word (address[9:2]) through the SRAM port. Such a write is dropped while a copy is running. Window reads return 0.
- R11: The retained word index wraps modulo 256 during a copy. The word count field is bits [8:0] of the count register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| ret_en | output | 1 | Retained SRAM access enable |
| ret_we | output | 1 | Retained SRAM write enable |
| ret_addr | output | 8 | Retained SRAM word index |
| ret_wdata | output | 32 | Retained SRAM write data |
| ret_rdata | input | 32 | Retained SRAM read data, one cycle after the read |
| imem_valid | output | 1 | Instruction write valid |
| imem_ready | input | 1 | Instruction SRAM accepts the write |
| imem_addr | output | 16 | Instruction write byte address |
| imem_data | output | 32 | Instruction write data |
| pwr_up | input | 1 | Power-up event pulse |
| cpu_hold | output | 1 | Holds the embedded processor while high |

## Verification
Faults in the word counters or the read-ahead queue show up at the instruction port on the very next handshake. They appear as a wrong address, a wrong or repeated data word, or a write after the Nth one. A reference model compares every handshake against its expected list on the same clock. A corrupted busy or hold state shows on `cpu_hold` one edge after the start or after the final write, and the model compares that pin every cycle. Arm and drop faults show only on a later stimulus, so each is followed by an observation: `cpu_hold` after a `pwr_up`, or the data of a later copy after a dropped window write.

// File: rtl/boot_copy_pkg.sv
package boot_copy_pkg;
  // register byte offsets inside the engine's space
  localparam int unsigned CTRL_OFS = 32'h000;
  localparam int unsigned SRC_OFS  = 32'h004;
  localparam int unsigned DST_OFS  = 32'h008;
  localparam int unsigned CNT_OFS  = 32'h00C;
  localparam int unsigned STAT_OFS = 32'h010;
  // control / status bit positions
  localparam int unsigned GO_BIT   = 31;
  localparam int unsigned ARM_BIT  = 30;
  localparam int unsigned DONE_BIT = 0;
  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned REG_W    = 32;
endpackage

// File: rtl/boot_copy_fifo.sv
module boot_copy_fifo #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 2,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          empty,
  output logic [CW-1:0] count
);
  logic [DW-1:0] store [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= push_data;
  end

  assign head  = store[rd_ptr];
  assign empty = (count == '0);

  // R4: read-ahead never overruns the queue
  p_fifo_room_r4: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> ((count < CW'(DEPTH)) || pop));
  p_fifo_nounder_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/boot_copy_csr.sv
module boot_copy_csr
  import boot_copy_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned RA_W   = 8,
  parameter int unsigned IA_W   = 16,
  parameter int unsigned CNT_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              pwr_up,
  input  logic              busy,
  input  logic              done,
  output logic              go,
  output logic [RA_W-1:0]   go_src,
  output logic [IA_W-1:0]   go_dst,
  output logic [CNT_W-1:0]  go_cnt,
  output logic              host_we,
  output logic [RA_W-1:0]   host_idx,
  output logic [REG_W-1:0]  host_wdata
);
  localparam int unsigned WIN_HI_W = ADDR_W - RA_W - 2;

  logic [REG_W-1:0] src_q, dst_q, cnt_q;
  logic             arm_q;
  logic sel_ctrl, sel_src, sel_dst, sel_cnt, sel_stat, sel_win;

  always_comb begin
    sel_ctrl = (reg_addr == ADDR_W'(CTRL_OFS));
    sel_src  = (reg_addr == ADDR_W'(SRC_OFS));
    sel_dst  = (reg_addr == ADDR_W'(DST_OFS));
    sel_cnt  = (reg_addr == ADDR_W'(CNT_OFS));
    sel_stat = (reg_addr == ADDR_W'(STAT_OFS));
    sel_win  = (reg_addr[ADDR_W-1:RA_W+2] == WIN_HI_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
      arm_q <= 1'b0;
    end else if (reg_wr) begin
      if (sel_ctrl) arm_q <= reg_wdata[ARM_BIT];
      if (sel_src)  src_q <= reg_wdata;
      if (sel_dst)  dst_q <= reg_wdata;
      if (sel_cnt)  cnt_q <= reg_wdata;
    end
  end

  assign go = !busy && ((reg_wr && sel_ctrl && reg_wdata[GO_BIT]) || (pwr_up && arm_q));
  assign go_src = src_q[RA_W+1:2];
  assign go_dst = dst_q[IA_W-1:0];
  assign go_cnt = cnt_q[CNT_W-1:0];

  assign host_we    = reg_wr && sel_win && !busy;
  assign host_idx   = reg_addr[RA_W+1:2];
  assign host_wdata = reg_wdata;

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      if (sel_ctrl) begin
        reg_rdata[GO_BIT]  = busy;
        reg_rdata[ARM_BIT] = arm_q;
      end
      if (sel_src)  reg_rdata = src_q;
      if (sel_dst)  reg_rdata = dst_q;
      if (sel_cnt)  reg_rdata = cnt_q;
      if (sel_stat) reg_rdata[DONE_BIT] = done;
    end
  end

  // R7: an unarmed power-up event never launches a copy
  p_unarmed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_up && !arm_q && !(reg_wr && sel_ctrl)) |-> !go);
endmodule

// File: rtl/boot_copy_mover.sv
module boot_copy_mover
  import boot_copy_pkg::*;
#(
  parameter int unsigned RA_W  = 8,
  parameter int unsigned IA_W  = 16,
  parameter int unsigned CNT_W = 9,
  parameter int unsigned DEPTH = 2,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [RA_W-1:0]  go_src,
  input  logic [IA_W-1:0]  go_dst,
  input  logic [CNT_W-1:0] go_cnt,
  output logic             rd_en,
  output logic [RA_W-1:0]  rd_idx,
  input  logic [REG_W-1:0] rd_data,
  output logic             imem_valid,
  input  logic             imem_ready,
  output logic [IA_W-1:0]  imem_addr,
  output logic [REG_W-1:0] imem_data,
  output logic             busy,
  output logic             done,
  output logic             cpu_hold
);
  logic             busy_q, done_q, hold_q, rd_pend;
  logic [CNT_W-1:0] rd_left, wr_left;
  logic [RA_W-1:0]  src_q;
  logic [IA_W-1:0]  dst_q;
  logic             f_empty, pop;
  logic [CW-1:0]    f_count;
  logic [CW:0]      occ, lim;

  boot_copy_fifo #(.DW(REG_W), .DEPTH(DEPTH)) u_ahead (
    .clk(clk), .rst_n(rst_n),
    .push(rd_pend), .push_data(rd_data),
    .pop(pop), .head(imem_data),
    .empty(f_empty), .count(f_count)
  );

  assign imem_valid = !f_empty;
  assign pop        = imem_valid && imem_ready;
  assign imem_addr  = dst_q;

  always_comb begin
    occ   = (CW+1)'(f_count) + (CW+1)'(rd_pend);
    lim   = (CW+1)'(DEPTH) + (CW+1)'(pop);
    rd_en = busy_q && (rd_left != '0) && (occ < lim);
  end
  assign rd_idx = src_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      hold_q  <= 1'b1;
      rd_pend <= 1'b0;
      rd_left <= '0;
      wr_left <= '0;
      src_q   <= '0;
      dst_q   <= '0;
    end else begin
      rd_pend <= rd_en;
      if (rd_en) begin
        src_q   <= src_q + RA_W'(1);
        rd_left <= rd_left - CNT_W'(1);
      end
      if (pop) begin
        dst_q   <= dst_q + IA_W'(WORD_BYTES);
        wr_left <= wr_left - CNT_W'(1);
        if (wr_left == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          hold_q <= 1'b0;
        end
      end
      if (go) begin
        busy_q  <= (go_cnt != '0);
        done_q  <= (go_cnt == '0);
        hold_q  <= (go_cnt != '0);
        rd_left <= go_cnt;
        wr_left <= go_cnt;
        src_q   <= go_src;
        dst_q   <= go_dst;
      end
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign cpu_hold = hold_q;

  // R5: stalled write keeps its payload
  p_stall_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (imem_valid && !imem_ready) |=> (imem_valid && $stable(imem_addr) && $stable(imem_data)));
  // R8: processor held for the whole copy
  p_hold_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> hold_q);
  // R6: empty copy finishes on its start edge
  p_zero_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (go && go_cnt == '0) |=> (done_q && !busy_q));
  // R2: end of copy reports done and releases
  p_finish_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> (done_q && !hold_q));
  // R9: no launch while a copy runs
  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy_q);
endmodule

// File: rtl/boot_copy_engine.sv
module boot_copy_engine
  import boot_copy_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned RET_WORDS = 256,
  parameter int unsigned IA_W      = 16,
  parameter int unsigned AHEAD     = 2,
  localparam int unsigned RA_W     = $clog2(RET_WORDS),
  localparam int unsigned CNT_W    = RA_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              ret_en,
  output logic              ret_we,
  output logic [RA_W-1:0]   ret_addr,
  output logic [31:0]       ret_wdata,
  input  logic [31:0]       ret_rdata,
  output logic              imem_valid,
  input  logic              imem_ready,
  output logic [IA_W-1:0]   imem_addr,
  output logic [31:0]       imem_data,
  input  logic              pwr_up,
  output logic              cpu_hold
);
  logic             busy, done, go, host_we, rd_en;
  logic [RA_W-1:0]  go_src, host_idx, rd_idx;
  logic [IA_W-1:0]  go_dst;
  logic [CNT_W-1:0] go_cnt;

  boot_copy_csr #(.ADDR_W(ADDR_W), .RA_W(RA_W), .IA_W(IA_W), .CNT_W(CNT_W)) u_csr (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pwr_up(pwr_up), .busy(busy), .done(done),
    .go(go), .go_src(go_src), .go_dst(go_dst), .go_cnt(go_cnt),
    .host_we(host_we), .host_idx(host_idx), .host_wdata(ret_wdata)
  );

  boot_copy_mover #(.RA_W(RA_W), .IA_W(IA_W), .CNT_W(CNT_W), .DEPTH(AHEAD)) u_mover (
    .clk(clk), .rst_n(rst_n),
    .go(go), .go_src(go_src), .go_dst(go_dst), .go_cnt(go_cnt),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(ret_rdata),
    .imem_valid(imem_valid), .imem_ready(imem_ready),
    .imem_addr(imem_addr), .imem_data(imem_data),
    .busy(busy), .done(done), .cpu_hold(cpu_hold)
  );

  assign ret_en   = rd_en || host_we;
  assign ret_we   = host_we;
  assign ret_addr = host_we ? host_idx : rd_idx;

  // R10: host window writes never reach the SRAM during a copy
  p_host_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ret_we);
  // R10: engine reads and host writes never collide
  p_port_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && host_we));
endmodule

// File: tb/boot_copy_engine_test.sv
`timescale 1ns/1ps
module boot_copy_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ret_en, ret_we;
  logic [7:0]  ret_addr;
  logic [31:0] ret_wdata, ret_rdata;
  logic        imem_valid, imem_ready;
  logic [15:0] imem_addr;
  logic [31:0] imem_data;
  logic        pwr_up = 1'b0;
  logic        cpu_hold;

  int checks = 0, fails = 0;
  int rmode = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  boot_copy_engine uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ret_en(ret_en), .ret_we(ret_we), .ret_addr(ret_addr),
    .ret_wdata(ret_wdata), .ret_rdata(ret_rdata),
    .imem_valid(imem_valid), .imem_ready(imem_ready),
    .imem_addr(imem_addr), .imem_data(imem_data),
    .pwr_up(pwr_up), .cpu_hold(cpu_hold)
  );

  // retained SRAM: registered read, one cycle latency
  logic [31:0] ret_mem [256];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) ret_mem[i] <= '0;
      ret_rdata <= '0;
    end else if (ret_en) begin
      if (ret_we) ret_mem[ret_addr] <= ret_wdata;
      else        ret_rdata <= ret_mem[ret_addr];
    end
  end

  // instruction-side ready pattern
  initial begin
    imem_ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      seed = seed * 32'd1103515245 + 32'd12345;
      imem_ready = (rmode == 0) ? 1'b1 : seed[17];
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- reference model, compared every clock ----------------
  logic        m_busy, m_done, m_hold, m_arm;
  logic [31:0] m_src, m_dst, m_cnt;
  logic [31:0] m_mem [256];
  logic [47:0] expq [$];
  logic        prev_stall;
  logic [15:0] prev_addr;
  logic [31:0] prev_data, last_data;

  always @(negedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_hold = 1; m_arm = 0;
      m_src = 0; m_dst = 0; m_cnt = 0;
      for (int i = 0; i < 256; i++) m_mem[i] = '0;
      expq.delete();
      prev_stall = 0;
      last_data = '0;
    end else begin
      automatic logic hs_last = 0;
      automatic logic start;
      automatic logic [31:0] o_src = m_src, o_dst = m_dst, o_cnt = m_cnt;
      automatic logic o_busy = m_busy;
      automatic logic [47:0] e;
      chk("R8 cpu_hold per cycle", cpu_hold, m_hold);
      if (prev_stall)
        chk("R5 stalled write held", {imem_valid, imem_addr, imem_data}, {1'b1, prev_addr, prev_data});
      if (!m_busy) chk("R9 no write while idle", imem_valid, 1'b0);
      if (imem_valid && imem_ready) begin
        if (expq.size() == 0) begin
          chk("R3 unexpected write", {imem_addr, imem_data}, 48'h0);
        end else begin
          e = expq.pop_front();
          chk("R3 write addr/data", {imem_addr, imem_data}, e);
          last_data = imem_data;
          hs_last = (expq.size() == 0);
        end
      end
      prev_stall = imem_valid && !imem_ready;
      prev_addr  = imem_addr;
      prev_data  = imem_data;
      // predict state after the coming edge
      start = !o_busy && ((reg_wr && reg_addr == 12'h000 && reg_wdata[31]) || (pwr_up && m_arm));
      if (hs_last) begin m_busy = 0; m_done = 1; m_hold = 0; end
      if (reg_wr) begin
        case (reg_addr)
          12'h000: m_arm = reg_wdata[30];
          12'h004: m_src = reg_wdata;
          12'h008: m_dst = reg_wdata;
          12'h00C: m_cnt = reg_wdata;
          default: if (reg_addr[11:10] == 2'b01 && !o_busy) m_mem[reg_addr[9:2]] = reg_wdata;
        endcase
      end
      if (start) begin
        if (o_cnt[8:0] == 0) begin
          m_done = 1; m_hold = 0;
        end else begin
          m_busy = 1; m_done = 0; m_hold = 1;
          for (int i = 0; i < int'(o_cnt[8:0]); i++)
            expq.push_back({o_dst[15:0] + 16'(4 * i), m_mem[(int'(o_src[9:2]) + i) % 256]});
        end
      end
    end
  end

  // ---------------- bus tasks ----------------
  task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic reg_read(input logic [11:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    reg_rd = 1; reg_addr = a;
    #1 d = reg_rdata;
    reg_rd = 0;
  endtask

  task automatic pulse_pwr();
    @(posedge clk); #1 pwr_up = 1;
    @(posedge clk); #1 pwr_up = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int k = 0; k < 3000; k++) begin
      reg_read(12'h000, v);
      if (!v[31]) break;
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  function automatic logic [31:0] pat(input int i);
    return 32'h5A00_0000 ^ (32'(i) * 32'h0001_0307);
  endfunction

  initial begin
    logic [31:0] v;
    int n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // reset state
    reg_read(12'h000, v); chk("R1 ctrl after reset", v, 32'h0);
    reg_read(12'h010, v); chk("R1 status after reset", v, 32'h0);
    chk("R8 hold out of reset", cpu_hold, 1'b1);
    chk("R3 no write after reset", imem_valid, 1'b0);

    // zero-count start (count reset value is 0)
    reg_write(12'h000, 32'h8000_0000);
    chk("R6 hold released on empty copy", cpu_hold, 1'b0);
    reg_read(12'h000, v); chk("R6 busy never shown", v[31], 1'b0);
    reg_read(12'h010, v); chk("R6 done set", v, 32'h1);

    // fill retained SRAM through the window
    for (int i = 0; i < 256; i++) reg_write(12'h400 + 12'(4 * i), pat(i));
    reg_write(12'h004, 32'hABCD_0040);
    reg_write(12'h008, 32'h0000_0200);
    reg_write(12'h00C, 32'h0000_0008);
    reg_read(12'h004, v); chk("R1 src readback", v, 32'hABCD_0040);
    reg_read(12'h008, v); chk("R1 dst readback", v, 32'h0000_0200);
    reg_read(12'h00C, v); chk("R1 count readback", v, 32'h0000_0008);
    reg_read(12'h404, v); chk("R10 window read is zero", v, 32'h0);

    // host start, busy polling
    reg_write(12'h000, 32'h8000_0000);
    reg_read(12'h000, v); chk("R2 busy during copy", v[31], 1'b1);
    reg_read(12'h010, v); chk("R2 done cleared at start", v[0], 1'b0);
    wait_idle();
    reg_read(12'h010, v); chk("R2 done after copy", v, 32'h1);
    chk("R3 all words written", expq.size(), 0);

    // throughput
    reg_write(12'h000, 32'h8000_0000);
    n = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (cpu_hold) n++; else break;
    end
    chk("R4 hold cycles for 8 words", n, 10);

    // back-pressure
    reg_write(12'h004, 32'h0);
    reg_write(12'h008, 32'h0000_1000);
    reg_write(12'h00C, 32'd40);
    rmode = 1;
    reg_write(12'h000, 32'h8000_0000);
    wait_idle();
    rmode = 0;
    chk("R5 nothing lost under stalls", expq.size(), 0);

    // index wrap
    reg_write(12'h004, 32'h0000_03F0);
    reg_write(12'h00C, 32'd8);
    reg_write(12'h000, 32'h8000_0000);
    wait_idle();
    chk("R11 wrapped copy complete", expq.size(), 0);

    // busy drops host window writes and restarts
    reg_write(12'h004, 32'h0);
    reg_write(12'h00C, 32'd40);
    rmode = 1;
    reg_write(12'h000, 32'h8000_0000);
    reg_write(12'h40C, 32'hDEAD_BEEF);
    reg_write(12'h000, 32'h8000_0000);
    wait_idle();
    rmode = 0;
    chk("R9 restart ignored, exact count", expq.size(), 0);
    reg_write(12'h004, 32'h0000_000C);
    reg_write(12'h00C, 32'd1);
    reg_write(12'h000, 32'h8000_0000);
    wait_idle();
    chk("R10 busy window write dropped", last_data, pat(3));
    reg_write(12'h40C, 32'h1234_5678);
    reg_write(12'h000, 32'h8000_0000);
    wait_idle();
    chk("R10 idle window write stored", last_data, 32'h1234_5678);

    // arm and power-up
    reg_write(12'h004, 32'h0000_0040);
    reg_write(12'h00C, 32'd4);
    pulse_pwr();
    repeat (6) @(posedge clk);
    #1 chk("R7 unarmed pwr_up ignored", cpu_hold, 1'b0);
    reg_write(12'h000, 32'h4000_0000);
    reg_read(12'h000, v); chk("R7 arm readback, no start", v, 32'h4000_0000);
    chk("R7 arm alone keeps processor running", cpu_hold, 1'b0);
    pulse_pwr();
    chk("R8 hold rises on pwr_up copy", cpu_hold, 1'b1);
    wait_idle();
    chk("R8 processor released after pwr_up copy", cpu_hold, 1'b0);
    reg_read(12'h010, v); chk("R7 pwr_up copy done", v, 32'h1);
    reg_write(12'h00C, 32'd30);
    rmode = 1;
    pulse_pwr();
    pulse_pwr();
    wait_idle();
    rmode = 0;
    chk("R9 pwr_up during copy ignored", expq.size(), 0);
    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule